// File: doc/BRIEF.md
# Store-Busy Line Handshake Controller

This controller arbitrates a shared, open-drain store/busy line against ordinary SRAM traffic in a memory with a non-volatile backing copy. A host or neighbouring device can pull the line low to request a store. The controller can also receive a software store request and a power-loss store request. The controller answers every store by pulling the line low itself for as long as the store runs. It blocks new writes, and later all accesses, during the store. It pulses a start strobe to the cell array and tells the dirty-flag logic to clear itself.

The line is sampled through a synchronizer and a low-width filter. Once an external low is accepted, the controller pulls the line low and opens a grace window. Reads keep flowing during that window. A write granted before the window opened has already finished. At the end of the window the controller checks the write-since-last-store flag. If it is set, the store runs. If it is clear, the store is skipped. In both cases the device then stays locked until the line is seen high again. A fixed recovery interval follows before access returns. A software request bypasses the grace window and the dirty check. It wins over a power-loss or line request that arrives in the same cycle.

States: IDLE, GRACE, START, RUN, HOLD, RECOVER. The transitions are:
- IDLE to START on a software request.
- IDLE to GRACE on a filtered line low or a power-loss request.
- GRACE to START (dirty) or to HOLD (clean) when the grace count ends.
- START to RUN after one cycle.
- RUN to HOLD when the store count ends.
- HOLD to RECOVER when the synchronized line is high.
- RECOVER to IDLE when the recovery count ends.

Top module: `store_busy_ctrl`

## Requirements
- R1: After reset, line_pull, wr_inhibit, acc_inhibit, busy, store_start and dirty_clr are all 0.
- R2: An external low must be present for at least MIN_LOW_SAMPLES consecutive clock samples to count as a request; a shorter low has no effect (busy and line_pull stay 0). An accepted low raises line_pull exactly SYNC_STAGES+MIN_LOW_SAMPLES+1 clock edges after its first sampling edge.
- R3: Writes are granted (wr_ok=1) while IDLE, even in the cycles where a line low is being filtered. From entry to GRACE onward wr_ok is 0, while rd_ok follows rd_req throughout GRACE.
- R4: At the end of GRACE, store_start and dirty_clr pulse for exactly one cycle if and only if wr_dirty is 1. After the store the dirty flag reads 0.
- R5: line_pull stays 1 without a gap for a whole store: GRACE_CYCLES+1+STORE_CYCLES cycles for a line or power-loss store, and 1+STORE_CYCLES cycles for a software store. It then falls to 0.
- R6: If wr_dirty is 0 at the end of GRACE, no store_start occurs. line_pull falls after GRACE_CYCLES cycles, and acc_inhibit stays 1.
- R7: After line_pull falls, acc_inhibit stays 1 and rd_ok and wr_ok stay 0 for as long as the line is held low externally.
- R8: acc_inhibit falls exactly SYNC_STAGES+RECOVER_CYCLES+1 clock edges after the first edge that samples the line high. At the observation point used by the bench, this is SYNC_STAGES+RECOVER_CYCLES+2 half-cycle-offset samples counted from the first high sample.
- R9: A software store request in IDLE gives store_start on the next clock edge, with no grace window, whatever the state of wr_dirty.
- R10: A software request in the same cycle as a power-loss request wins: the store runs even with wr_dirty at 0, with a software-length pull.
- R11: A power-loss store request behaves like an external line request: it opens a grace window and stores only when wr_dirty is 1.
- R12: busy is 1 from the first cycle of a store or skip sequence until acc_inhibit falls, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | 1 | Sensed level of the store/busy line (1 = high) |
| wr_dirty | input | 1 | A write has occurred since the last store or recall |
| rd_req | input | 1 | SRAM read request strobe |
| wr_req | input | 1 | SRAM write request strobe |
| sw_store_req | input | 1 | Software-initiated store request |
| pwr_store_req | input | 1 | Power-loss store request |
| line_pull | output | 1 | Open-drain pull-down enable for the line |
| wr_inhibit | output | 1 | New SRAM writes refused |
| acc_inhibit | output | 1 | All SRAM accesses refused |
| store_start | output | 1 | One-cycle start strobe to the cell array |
| dirty_clr | output | 1 | One-cycle clear for the write-since flag |
| busy | output | 1 | Store or lockout sequence in progress |
| rd_ok | output | 1 | Read request granted this cycle |
| wr_ok | output | 1 | Write request granted this cycle |

## Verification
Two collisions are exercised. In the first, a write strobe is held while the external low is still in the filter. The write must be granted in that cycle and set the dirty flag, so the store that follows must run; the write must be refused once GRACE begins. In the second, a software request and a power-loss request are raised on the same edge with the dirty flag clear. The scoreboard must see a start strobe and a pull length of 1+STORE_CYCLES, not the grace-only pull of a skipped store.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRACE   = 3'd1,
        ST_START   = 3'd2,
        ST_RUN     = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RECOVER = 3'd5
    } sbc_state_e;

    typedef struct packed {
        logic pull;
        logic wr_block;
        logic all_block;
        logic start;
        logic clr;
        logic busy;
    } sbc_drive_t;

endpackage

// File: rtl/sbc_line_filter.sv
`timescale 1ns/1ps
module sbc_line_filter #(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_LOW_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_lvl,
    output logic low_seen,
    output logic high_seen
);
    localparam int LW = $clog2(MIN_LOW_SAMPLES + 1);
    localparam logic [LW-1:0] LOW_FULL = LW'(MIN_LOW_SAMPLES);

    logic [SYNC_STAGES-1:0] chain_q;
    logic [LW-1:0]          low_run_q;
    logic                   lvl_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_lvl;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_lvl};
            end
        end
    endgenerate

    assign lvl_s = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (lvl_s) begin
            low_run_q <= '0;
        end else if (low_run_q != LOW_FULL) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    assign low_seen  = (low_run_q == LOW_FULL);
    assign high_seen = lvl_s;
endmodule

// File: rtl/sbc_tick.sv
`timescale 1ns/1ps
module sbc_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else            count <= count + 1'b1;
    end
endmodule

// File: rtl/sbc_fsm.sv
`timescale 1ns/1ps
module sbc_fsm
    import sbc_pkg::*;
#(
    parameter int GRACE_CYCLES   = 8,
    parameter int STORE_CYCLES   = 1250000,
    parameter int RECOVER_CYCLES = 88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_seen,
    input  logic       high_seen,
    input  logic       sw_req,
    input  logic       pwr_req,
    input  logic       wr_dirty,
    output sbc_drive_t drv
);
    localparam int MAX_GS = (GRACE_CYCLES > STORE_CYCLES) ? GRACE_CYCLES : STORE_CYCLES;
    localparam int MAXC   = (MAX_GS > RECOVER_CYCLES) ? MAX_GS : RECOVER_CYCLES;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GRACE_LAST   = CW'(GRACE_CYCLES - 1);
    localparam logic [CW-1:0] STORE_LAST   = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] RECOVER_LAST = CW'(RECOVER_CYCLES - 1);

    sbc_state_e    state_q, state_d;
    logic [CW-1:0] cnt;

    sbc_tick #(.W(CW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .count (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_req)                   state_d = ST_START;
                else if (low_seen || pwr_req) state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (cnt == GRACE_LAST) state_d = wr_dirty ? ST_START : ST_HOLD;
            end
            ST_START:   state_d = ST_RUN;
            ST_RUN: begin
                if (cnt == STORE_LAST) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (high_seen) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (cnt == RECOVER_LAST) state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drv = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRACE: begin
                drv.pull     = 1'b1;
                drv.wr_block = 1'b1;
                drv.busy     = 1'b1;
            end
            ST_START: begin
                drv.pull      = 1'b1;
                drv.wr_block  = 1'b1;
                drv.all_block = 1'b1;
                drv.start     = 1'b1;
                drv.clr       = 1'b1;
                drv.busy      = 1'b1;
            end
            ST_RUN: begin
                drv.pull      = 1'b1;
                drv.wr_block  = 1'b1;
                drv.all_block = 1'b1;
                drv.busy      = 1'b1;
            end
            ST_HOLD, ST_RECOVER: begin
                drv.wr_block  = 1'b1;
                drv.all_block = 1'b1;
                drv.busy      = 1'b1;
            end
            default: drv = '0;
        endcase
    end
endmodule

// File: rtl/store_busy_ctrl.sv
`timescale 1ns/1ps
module store_busy_ctrl
    import sbc_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_LOW_SAMPLES = 2,
    parameter int GRACE_CYCLES    = 8,
    parameter int STORE_CYCLES    = 1250000,
    parameter int RECOVER_CYCLES  = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_lvl,
    input  logic wr_dirty,
    input  logic rd_req,
    input  logic wr_req,
    input  logic sw_store_req,
    input  logic pwr_store_req,
    output logic line_pull,
    output logic wr_inhibit,
    output logic acc_inhibit,
    output logic store_start,
    output logic dirty_clr,
    output logic busy,
    output logic rd_ok,
    output logic wr_ok
);
    logic       low_seen;
    logic       high_seen;
    sbc_drive_t drv;

    sbc_line_filter #(
        .SYNC_STAGES     (SYNC_STAGES),
        .MIN_LOW_SAMPLES (MIN_LOW_SAMPLES)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_lvl  (line_lvl),
        .low_seen  (low_seen),
        .high_seen (high_seen)
    );

    sbc_fsm #(
        .GRACE_CYCLES   (GRACE_CYCLES),
        .STORE_CYCLES   (STORE_CYCLES),
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_seen  (low_seen),
        .high_seen (high_seen),
        .sw_req    (sw_store_req),
        .pwr_req   (pwr_store_req),
        .wr_dirty  (wr_dirty),
        .drv       (drv)
    );

    assign line_pull   = drv.pull;
    assign wr_inhibit  = drv.wr_block;
    assign acc_inhibit = drv.all_block;
    assign store_start = drv.start;
    assign dirty_clr   = drv.clr;
    assign busy        = drv.busy;
    assign rd_ok       = rd_req & ~drv.all_block;
    assign wr_ok       = wr_req & ~drv.wr_block & ~drv.all_block;
endmodule

// File: rtl/store_busy_ctrl_chk.sv
`timescale 1ns/1ps
module store_busy_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic line_lvl,
    input logic wr_dirty,
    input logic sw_store_req,
    input logic rd_req,
    input logic line_pull,
    input logic acc_inhibit,
    input logic store_start,
    input logic busy,
    input logic rd_ok,
    input logic wr_ok
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> !store_start); // R4

    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |-> ($past(wr_dirty) || $past(sw_store_req))); // R9

    AST_GRACE_READS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_pull) && !store_start) |-> (rd_ok == rd_req)); // R3

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !wr_ok); // R3

    AST_LOCKED_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull) |-> acc_inhibit); // R7

    AST_UNLOCK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(line_lvl)); // R8
endmodule

bind store_busy_ctrl store_busy_ctrl_chk u_sbc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_lvl     (line_lvl),
    .wr_dirty     (wr_dirty),
    .sw_store_req (sw_store_req),
    .rd_req       (rd_req),
    .line_pull    (line_pull),
    .acc_inhibit  (acc_inhibit),
    .store_start  (store_start),
    .busy         (busy),
    .rd_ok        (rd_ok),
    .wr_ok        (wr_ok)
);

// File: tb/test_store_busy_ctrl.sv
`timescale 1ns/1ps
module test_store_busy_ctrl;
    localparam int SYNC    = 2;
    localparam int MINLOW  = 2;
    localparam int GRACE   = 4;
    localparam int STORE   = 20;
    localparam int RECOVER = 6;

    localparam int EV_START   = 1;
    localparam int EV_RELEASE = 2;
    localparam int EV_READY   = 3;

    typedef struct {
        int kind;
        int val;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic dirty = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0, sw_req = 1'b0, pwr_req = 1'b0;
    logic line_lvl;
    logic line_pull, wr_inhibit, acc_inhibit, store_start, dirty_clr, busy, rd_ok, wr_ok;

    int checks = 0;
    int errors = 0;
    ev_t exp_q[$];

    always #4 clk = ~clk;

    assign line_lvl = ~(ext_low | line_pull);

    always_ff @(posedge clk) begin
        if (dirty_clr)  dirty <= 1'b0;
        else if (wr_ok) dirty <= 1'b1;
    end

    store_busy_ctrl #(
        .SYNC_STAGES(SYNC), .MIN_LOW_SAMPLES(MINLOW), .GRACE_CYCLES(GRACE),
        .STORE_CYCLES(STORE), .RECOVER_CYCLES(RECOVER)
    ) i_store_busy_ctrl (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .wr_dirty(dirty),
        .rd_req(rd_req), .wr_req(wr_req), .sw_store_req(sw_req), .pwr_store_req(pwr_req),
        .line_pull(line_pull), .wr_inhibit(wr_inhibit), .acc_inhibit(acc_inhibit),
        .store_start(store_start), .dirty_clr(dirty_clr), .busy(busy),
        .rd_ok(rd_ok), .wr_ok(wr_ok)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic push(input int kind, input int val, input string req);
        ev_t e;
        e.kind = kind;
        e.val  = val;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // monitor: turns output edges into events and compares them with the queue
    logic prev_pull = 1'b0, prev_acc = 1'b0;
    int pull_run = 0, hi_run = 0;
    always @(negedge clk) begin
        ev_t got;
        #2;
        got.req = "";
        if (rst_n) begin
            hi_run = line_lvl ? hi_run + 1 : 0;
            if (line_pull) pull_run++;
            got.kind = 0;
            if (store_start) begin
                got.kind = EV_START; got.val = 0;
            end else if (prev_pull && !line_pull) begin
                got.kind = EV_RELEASE; got.val = pull_run; pull_run = 0;
            end else if (prev_acc && !acc_inhibit) begin
                got.kind = EV_READY; got.val = hi_run;
            end
            if (got.kind != 0) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected event", got.kind, 0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " event kind"}, got.kind, e.kind);
                    chk({e.req, " event value"}, got.val, e.val);
                end
            end
            prev_pull = line_pull;
            prev_acc  = acc_inhibit;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        #2;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk); #2; n++;
        end
        chk({req, " returns to idle"}, int'(busy), 0);
        chk({req, " access re-enabled"}, int'(acc_inhibit), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        cyc(4);
        @(negedge clk); rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 line_pull", int'(line_pull), 0);
        chk("R1 wr_inhibit", int'(wr_inhibit), 0);
        chk("R1 acc_inhibit", int'(acc_inhibit), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 store_start", int'(store_start), 0);
        chk("R1 dirty_clr", int'(dirty_clr), 0);

        // R2 a single-sample low is filtered out
        @(negedge clk); ext_low = 1'b1;
        @(negedge clk); ext_low = 1'b0;
        cyc(10);
        chk("R2 short low ignored busy", int'(busy), 0);
        chk("R2 short low ignored pull", int'(line_pull), 0);

        // R3/R4/R5/R7/R8/R12 line store with a write colliding in the filter window
        push(EV_START, 0, "R4");
        push(EV_RELEASE, GRACE + 1 + STORE, "R5");
        push(EV_READY, SYNC + RECOVER + 2, "R8");
        @(negedge clk); ext_low = 1'b1; wr_req = 1'b1; rd_req = 1'b1;
        #2;
        chk("R3 write granted while idle", int'(wr_ok), 1);
        n = 0;
        while (!line_pull && n < 50) begin
            @(negedge clk); #2; n++;
        end
        chk("R2 pull latency", n, SYNC + MINLOW + 1);
        chk("R12 busy in grace", int'(busy), 1);
        chk("R3 write refused in grace", int'(wr_ok), 0);
        chk("R3 read granted in grace", int'(rd_ok), 1);
        @(negedge clk); wr_req = 1'b0;
        cyc(GRACE + STORE + 12);
        chk("R7 pull released", int'(line_pull), 0);
        chk("R7 still locked", int'(acc_inhibit), 1);
        chk("R7 read refused while held", int'(rd_ok), 0);
        chk("R4 dirty cleared", int'(dirty), 0);
        @(negedge clk); ext_low = 1'b0; rd_req = 1'b0;
        cyc(1);
        wait_idle("R8");

        // R6 two-sample low, nothing dirty: skip
        push(EV_RELEASE, GRACE, "R6");
        push(EV_READY, SYNC + RECOVER + 2, "R6");
        @(negedge clk); ext_low = 1'b1;
        @(negedge clk);
        @(negedge clk); ext_low = 1'b0;
        cyc(8);
        chk("R6 locked after skip", int'(acc_inhibit), 1);
        wait_idle("R6");

        // R9 software store, no grace, dirty clear
        push(EV_START, 0, "R9");
        push(EV_RELEASE, 1 + STORE, "R9");
        push(EV_READY, SYNC + RECOVER + 2, "R9");
        @(negedge clk); sw_req = 1'b1;
        @(negedge clk); sw_req = 1'b0; #2;
        chk("R9 start without grace", int'(store_start), 1);
        cyc(3);
        wait_idle("R9");

        // R10 software and power-loss in the same cycle, dirty clear
        push(EV_START, 0, "R10");
        push(EV_RELEASE, 1 + STORE, "R10");
        push(EV_READY, SYNC + RECOVER + 2, "R10");
        @(negedge clk); sw_req = 1'b1; pwr_req = 1'b1;
        @(negedge clk); sw_req = 1'b0; pwr_req = 1'b0;
        cyc(3);
        wait_idle("R10");

        // R11 power-loss store after a write
        @(negedge clk); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        cyc(1);
        chk("R11 dirty set by write", int'(dirty), 1);
        push(EV_START, 0, "R11");
        push(EV_RELEASE, GRACE + 1 + STORE, "R11");
        push(EV_READY, SYNC + RECOVER + 2, "R11");
        @(negedge clk); pwr_req = 1'b1;
        @(negedge clk); pwr_req = 1'b0;
        cyc(3);
        wait_idle("R11");
        chk("R11 dirty cleared", int'(dirty), 0);

        // R11 power-loss request with nothing dirty: skipped
        push(EV_RELEASE, GRACE, "R11");
        push(EV_READY, SYNC + RECOVER + 2, "R11");
        @(negedge clk); pwr_req = 1'b1;
        @(negedge clk); pwr_req = 1'b0;
        cyc(3);
        wait_idle("R11");

        cyc(4);
        chk("R12 all expected events seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule